// File: doc/BRIEF.md
# Parallel Transformed-State Remainder Encoder

This block divides a binary message by a fixed generator polynomial of degree DEG and returns the remainder, which is the parity field of a CRC or systematic BCH encoder. It takes DEG message bits in every clock cycle. The result is exactly what a one-bit-per-clock shift register would produce. That serial register starts at zero, feeds each input bit XORed with its top stage back through the generator taps, and so yields x^DEG·M(x) mod g(x).

The DEG-step update is carried out in a changed coordinate system. At elaboration a basis matrix T is built and inverted over GF(2). The basis is chosen so that the matrix inside the register loop has companion form. Each loop update is therefore a one-place shift plus XOR taps taken from the top state bit. The dense input-mixing matrix sits ahead of the loop and the dense T matrix sits behind it, where their depth does not limit the loop. Elaboration stops with an error if T turns out singular or if the loop matrix is not a companion matrix.

A message is a run of full words. The first word carries the start marker and the final word carries the last marker. The remainder and a done pulse appear in the cycle after the last word.

Top module: `pss_lfsr_enc`

## Requirements
- R1: After synchronous reset, rem_out is all zeros and rem_done is 0.
- R2: For a message of whole words, rem_out after the last word equals x^DEG·M(x) mod g(x), the value a zero-initialised serial divider gives. That divider takes in_data[DEG-1] of each word first and bit 0 last; with GPOLY=8'h07 the nine ASCII bytes "123456789" give 8'hF4.
- R3: A word accepted with in_start high is folded into a zero state, so earlier words have no effect on the result; a start word of all zeros leaves rem_out at zero.
- R4: rem_done is 1 in exactly the cycle after a word with in_last is accepted, and 0 in every other cycle.
- R5: While in_valid is 0, in_data, in_start and in_last are ignored and rem_out keeps its value.
- R6: A one-word message (in_start and in_last both high) gives the correct remainder.
- R7: A new message may begin in the cycle right after a last word, and both remainders are correct.
- R8: The same RTL with GPOLY=8'hD1 (g = x^8+x^7+x^6+x^4+1) gives the serial divider's parity for that generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on in_data is taken this cycle |
| in_start | input | 1 | Word is the first of a message (acts with in_valid) |
| in_last | input | 1 | Word is the final one of a message (acts with in_valid) |
| in_data | input | DEG | Message word, bit DEG-1 earliest in time |
| rem_out | output | DEG | Remainder mapped back from the transformed state |
| rem_done | output | 1 | One-cycle pulse: rem_out holds a finished remainder |

## Verification
rem_out is the T-mapped transformed state in every cycle, not only at the end. An error in a loop tap, an input-mixing column or the transform shows up in the cycle after the first word it affects. It also shows up in the final remainder, which the checks compare against a serial divider for two generators. A state that changes during an idle cycle shows up one cycle later as a moving rem_out. A start that fails to clear shows up as a wrong remainder after a restart.

// File: rtl/pss_lfsr_pkg.sv
package pss_lfsr_pkg;

    localparam int MAXD = 32;

    typedef logic [MAXD-1:0]            vec_t;
    typedef logic [MAXD-1:0][MAXD-1:0]  mat_t;   // [row][col]

    typedef struct packed {
        logic ok;
        mat_t m;
    } inv_t;

    typedef struct packed {
        logic valid;
        logic start;
        logic last;
    } word_ctl_t;

    function automatic mat_t identity(int d);
        mat_t r = '0;
        for (int i = 0; i < d; i++) r[i][i] = 1'b1;
        return r;
    endfunction

    // One serial step: shift up, top bit fed back through the taps
    function automatic mat_t serial_step(vec_t g, int d);
        mat_t a = '0;
        for (int i = 1; i < d; i++) a[i][i-1] = 1'b1;
        for (int i = 0; i < d; i++) a[i][d-1] = a[i][d-1] ^ g[i];
        return a;
    endfunction

    function automatic mat_t gf2_mul(mat_t a, mat_t b, int d);
        mat_t c = '0;
        for (int i = 0; i < d; i++)
            for (int j = 0; j < d; j++) begin
                logic acc = 1'b0;
                for (int k = 0; k < d; k++) acc = acc ^ (a[i][k] & b[k][j]);
                c[i][j] = acc;
            end
        return c;
    endfunction

    function automatic vec_t gf2_mv(mat_t a, vec_t v, int d);
        vec_t r = '0;
        for (int i = 0; i < d; i++)
            for (int k = 0; k < d; k++) r[i] = r[i] ^ (a[i][k] & v[k]);
        return r;
    endfunction

    function automatic mat_t gf2_pow(mat_t a, int n, int d);
        mat_t r = identity(d);
        for (int i = 0; i < n; i++) r = gf2_mul(r, a, d);
        return r;
    endfunction

    // Column j = a^j * s
    function automatic mat_t krylov(mat_t a, vec_t s, int d);
        mat_t t = '0;
        vec_t v = s;
        for (int j = 0; j < d; j++) begin
            for (int i = 0; i < d; i++) t[i][j] = v[i];
            v = gf2_mv(a, v, d);
        end
        return t;
    endfunction

    // Input matrix of p serial steps: column j = a^j * g (bit 0 is shifted last)
    function automatic mat_t in_matrix(mat_t a, vec_t g, int d, int p);
        mat_t b = '0;
        vec_t v = g;
        for (int j = 0; j < p; j++) begin
            for (int i = 0; i < d; i++) b[i][j] = v[i];
            v = gf2_mv(a, v, d);
        end
        return b;
    endfunction

    // Gauss-Jordan inversion over GF(2)
    function automatic inv_t gf2_inv(mat_t a, int d);
        mat_t w = a;
        mat_t v = identity(d);
        logic ok = 1'b1;
        inv_t res;
        for (int c = 0; c < d; c++) begin
            int   pr = c;
            logic found = 1'b0;
            for (int r = c; r < d; r++)
                if (!found && w[r][c]) begin
                    pr    = r;
                    found = 1'b1;
                end
            if (!found) begin
                ok = 1'b0;
            end else begin
                vec_t tw = w[c];
                vec_t tv = v[c];
                w[c]  = w[pr];
                v[c]  = v[pr];
                w[pr] = tw;
                v[pr] = tv;
                for (int r = 0; r < d; r++)
                    if (r != c && w[r][c]) begin
                        w[r] = w[r] ^ w[c];
                        v[r] = v[r] ^ v[c];
                    end
            end
        end
        res.ok = ok;
        res.m  = v;
        return res;
    endfunction

    // First start vector from s0 on that gives an invertible basis
    function automatic vec_t find_seed(mat_t ap, vec_t s0, int d);
        vec_t s    = s0;
        vec_t best = s0;
        logic got  = 1'b0;
        inv_t tr;
        for (int t = 0; t < 16; t++) begin
            if (!got && s != '0) begin
                tr = gf2_inv(krylov(ap, s, d), d);
                if (tr.ok) begin
                    best = s;
                    got  = 1'b1;
                end
            end
            s = s + vec_t'(1);
        end
        return best;
    endfunction

    function automatic vec_t get_col(mat_t a, int c, int d);
        vec_t v = '0;
        for (int i = 0; i < d; i++) v[i] = a[i][c];
        return v;
    endfunction

    function automatic logic is_companion(mat_t a, int d);
        logic ok = 1'b1;
        for (int i = 0; i < d; i++)
            for (int j = 0; j < d - 1; j++)
                if (a[i][j] != (i == j + 1)) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/gf2_matvec.sv
module gf2_matvec
    import pss_lfsr_pkg::*;
#(
    parameter int   ROWS = 8,
    parameter int   COLS = 8,
    parameter mat_t MAT  = '0
) (
    input  logic [COLS-1:0] vin,
    output logic [ROWS-1:0] vout
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign vout[r] = ^(MAT[r][COLS-1:0] & vin);
    end

endmodule

// File: rtl/pss_loop.sv
module pss_loop
    import pss_lfsr_pkg::*;
#(
    parameter int   D    = 8,
    parameter vec_t TAPS = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  word_ctl_t    ctl,
    input  logic [D-1:0] mix,
    output logic [D-1:0] state
);

    logic [D-1:0] base;
    logic [D-1:0] shifted;

    assign base = ctl.start ? '0 : state;

    // Companion update: shift by one, top bit fed back to the tap rows
    assign shifted[0] = TAPS[0] & base[D-1];
    for (genvar i = 1; i < D; i++) begin : g_cmp
        assign shifted[i] = base[i-1] ^ (TAPS[i] & base[D-1]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= '0;
        else if (ctl.valid)
            state <= shifted ^ mix;
    end

endmodule

// File: rtl/pss_lfsr_enc.sv
module pss_lfsr_enc
    import pss_lfsr_pkg::*;
#(
    parameter int             DEG   = 8,
    parameter logic [DEG-1:0] GPOLY = 8'h07,
    parameter int             SEED  = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           in_start,
    input  logic           in_last,
    input  logic [DEG-1:0] in_data,
    output logic [DEG-1:0] rem_out,
    output logic           rem_done
);

    localparam int   P     = DEG;
    localparam vec_t GV    = vec_t'(GPOLY);
    localparam mat_t A1    = serial_step(GV, DEG);
    localparam mat_t AP    = gf2_pow(A1, P, DEG);
    localparam mat_t BP    = in_matrix(A1, GV, DEG, P);
    localparam vec_t SV    = find_seed(AP, vec_t'(SEED), DEG);
    localparam mat_t TM    = krylov(AP, SV, DEG);
    localparam inv_t TIR   = gf2_inv(TM, DEG);
    localparam mat_t TI    = TIR.m;
    localparam mat_t CL    = gf2_mul(gf2_mul(TI, AP, DEG), TM, DEG);
    localparam mat_t BT    = gf2_mul(TI, BP, DEG);
    localparam vec_t TAPS  = get_col(CL, DEG - 1, DEG);

    if (DEG < 2 || DEG > MAXD) begin : g_bad_deg
        $error("pss_lfsr_enc: DEG out of range");
    end
    if (!TIR.ok) begin : g_singular
        $error("pss_lfsr_enc: transform basis is singular");
    end
    if (!is_companion(CL, DEG)) begin : g_not_cmp
        $error("pss_lfsr_enc: loop matrix is not in companion form");
    end

    word_ctl_t      ctl;
    logic [DEG-1:0] mix;
    logic [DEG-1:0] xstate;

    assign ctl = '{valid: in_valid, start: in_start, last: in_last};

    // Input mixing, outside the loop
    gf2_matvec #(.ROWS(DEG), .COLS(P), .MAT(BT)) mix_i (
        .vin  (in_data),
        .vout (mix)
    );

    pss_loop #(.D(DEG), .TAPS(TAPS)) loop_i (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .mix   (mix),
        .state (xstate)
    );

    // Map back to the true remainder, outside the loop
    gf2_matvec #(.ROWS(DEG), .COLS(DEG), .MAT(TM)) out_i (
        .vin  (xstate),
        .vout (rem_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rem_done <= 1'b0;
        else
            rem_done <= ctl.valid & ctl.last;
    end

endmodule

// File: rtl/pss_lfsr_enc_chk.sv
module pss_lfsr_enc_chk #(
    parameter int DEG = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic           in_start,
    input logic           in_last,
    input logic [DEG-1:0] in_data,
    input logic [DEG-1:0] rem_out,
    input logic           rem_done
);

    // R1
    rst_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (rem_done == 1'b0 && rem_out == '0));

    // R4
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> rem_done);

    // R4
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rem_done |-> $past(in_valid && in_last));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> (rem_out == $past(rem_out)));

    // R3
    start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_start && in_data == '0) |=> (rem_out == '0));

endmodule

bind pss_lfsr_enc pss_lfsr_enc_chk #(.DEG(DEG)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_last  (in_last),
    .in_data  (in_data),
    .rem_out  (rem_out),
    .rem_done (rem_done)
);

// File: tb/pss_lfsr_enc_tb.sv
module pss_lfsr_enc_tb_top;

    localparam logic [7:0] G_CRC = 8'h07;
    localparam logic [7:0] G_BCH = 8'hD1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic       in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [7:0] rem_c, rem_b;
    logic       done_c, done_b;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pss_lfsr_enc #(.DEG(8), .GPOLY(G_CRC), .SEED(1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_data(in_data), .rem_out(rem_c), .rem_done(done_c)
    );

    pss_lfsr_enc #(.DEG(8), .GPOLY(G_BCH), .SEED(1)) bch_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_data(in_data), .rem_out(rem_b), .rem_done(done_b)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ser_rem(logic [7:0] g, logic [7:0] m [16], int n);
        logic [7:0] r = 8'h00;
        logic       fb;
        for (int w = 0; w < n; w++)
            for (int b = 7; b >= 0; b--) begin
                fb = r[7] ^ m[w][b];
                r  = {r[6:0], 1'b0} ^ (fb ? g : 8'h00);
            end
        return r;
    endfunction

    task automatic go_idle();
        in_valid = 1'b0;
        in_start = 1'b0;
        in_last  = 1'b0;
        in_data  = 8'h00;
    endtask

    // Drive a message back to back and check both encoders
    task automatic run_msg(logic [7:0] m [16], int n, string req);
        logic [7:0] ec = ser_rem(G_CRC, m, n);
        logic [7:0] eb = ser_rem(G_BCH, m, n);
        @(negedge clk);
        for (int w = 0; w < n; w++) begin
            in_valid = 1'b1;
            in_start = (w == 0);
            in_last  = (w == n - 1);
            in_data  = m[w];
            @(negedge clk);
            if (w < n - 1) chk({req, " R4 no early done"}, {7'd0, done_c}, 8'd0);
        end
        chk({req, " CRC remainder"}, rem_c, ec);
        chk({req, " R8 BCH parity"}, rem_b, eb);
        chk({req, " R4 done"}, {7'd0, done_c & done_b}, 8'd1);
        go_idle();
        @(negedge clk);
        chk({req, " R4 done one cycle"}, {7'd0, done_c | done_b}, 8'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        go_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset rem CRC", rem_c, 8'h00);
        chk("R1 reset rem BCH", rem_b, 8'h00);
        chk("R1 reset done", {7'd0, done_c | done_b}, 8'd0);
    endtask

    task automatic t_known();
        logic [7:0] m [16];
        for (int k = 0; k < 16; k++) m[k] = 8'h00;
        for (int k = 0; k < 9; k++) m[k] = 8'h31 + 8'(k);
        run_msg(m, 9, "R2 known vector");
        chk("R2 check value F4", rem_c, 8'hF4);
    endtask

    task automatic t_random();
        logic [7:0] m [16];
        for (int t = 0; t < 40; t++) begin
            int n = 1 + int'($urandom_range(0, 15));
            for (int k = 0; k < 16; k++) m[k] = 8'($urandom);
            run_msg(m, n, "R2 random");
        end
    endtask

    task automatic t_zero_msg();
        logic [7:0] m [16];
        for (int k = 0; k < 16; k++) m[k] = 8'h00;
        run_msg(m, 5, "R2 zero message");
        chk("R2 zero gives zero", rem_c | rem_b, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] m [16];
        logic [7:0] vals [4] = '{8'h80, 8'h01, 8'hFF, 8'h5A};
        for (int k = 0; k < 16; k++) m[k] = 8'h00;
        for (int v = 0; v < 4; v++) begin
            m[0] = vals[v];
            run_msg(m, 1, "R6 one word");
        end
    endtask

    // Idle cycles with garbage between words
    task automatic t_stall();
        logic [7:0] m [16];
        logic [7:0] hc, hb;
        int n = 6;
        for (int k = 0; k < 16; k++) m[k] = 8'($urandom);
        @(negedge clk);
        for (int w = 0; w < n; w++) begin
            in_valid = 1'b1;
            in_start = (w == 0);
            in_last  = (w == n - 1);
            in_data  = m[w];
            @(negedge clk);
            hc = rem_c;
            hb = rem_b;
            if (w == n - 1) begin
                chk("R5 stalled CRC remainder", rem_c, ser_rem(G_CRC, m, n));
                chk("R5 stalled BCH parity", rem_b, ser_rem(G_BCH, m, n));
            end else begin
                in_valid = 1'b0;
                in_start = 1'b1;
                in_last  = 1'b1;
                in_data  = 8'($urandom);
                @(negedge clk);
                chk("R5 idle holds CRC", rem_c, hc);
                chk("R5 idle holds BCH", rem_b, hb);
                chk("R5 idle no done", {7'd0, done_c | done_b}, 8'd0);
            end
        end
        go_idle();
        @(negedge clk);
    endtask

    // Abandon a message mid-way; the restart must discard it
    task automatic t_restart();
        logic [7:0] m [16];
        @(negedge clk);
        for (int w = 0; w < 3; w++) begin
            in_valid = 1'b1;
            in_start = (w == 0);
            in_last  = 1'b0;
            in_data  = 8'($urandom) | 8'h01;
            @(negedge clk);
        end
        go_idle();
        for (int k = 0; k < 16; k++) m[k] = 8'($urandom);
        run_msg(m, 4, "R3 restart");
        @(negedge clk);
        for (int w = 0; w < 2; w++) begin
            in_valid = 1'b1;
            in_start = (w == 0);
            in_data  = 8'hC3;
            @(negedge clk);
        end
        in_start = 1'b1;
        in_data  = 8'h00;
        @(negedge clk);
        chk("R3 zero start word clears", rem_c | rem_b, 8'h00);
        go_idle();
        @(negedge clk);
    endtask

    task automatic t_b2b();
        logic [7:0] a [16], b [16];
        int na = 3, nb = 5;
        for (int k = 0; k < 16; k++) begin
            a[k] = 8'($urandom);
            b[k] = 8'($urandom);
        end
        @(negedge clk);
        for (int w = 0; w < na + nb; w++) begin
            if (w == na) begin
                chk("R7 first CRC", rem_c, ser_rem(G_CRC, a, na));
                chk("R7 first BCH", rem_b, ser_rem(G_BCH, a, na));
                chk("R7 first done", {7'd0, done_c}, 8'd1);
            end
            in_valid = 1'b1;
            in_start = (w == 0) || (w == na);
            in_last  = (w == na - 1) || (w == na + nb - 1);
            in_data  = (w < na) ? a[w] : b[w - na];
            @(negedge clk);
        end
        chk("R7 second CRC", rem_c, ser_rem(G_CRC, b, nb));
        chk("R7 second BCH", rem_b, ser_rem(G_BCH, b, nb));
        chk("R7 second done", {7'd0, done_b}, 8'd1);
        go_idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        t_reset();
        t_known();
        t_zero_msg();
        t_single();
        t_random();
        t_stall();
        t_restart();
        t_b2b();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule